// File: doc/BRIEF.md
# Masked Data Value Qualifier

This block sits behind an address comparator (or an address-range pair) in a debug and trace filter. The comparator reports an address hit. This block then confirms or rejects that hit by comparing the value on the data bus with a programmed reference word. The comparison uses only the bits that a programmable mask leaves in play. The result is one qualified-match strobe, which downstream event logic can use directly.

The comparison has meaning only for data transfers. It is evaluated in cycles where a load or store is presented, and a direction filter can narrow it to loads only or to stores only. An inverted-sense option turns it into a "data differs" match. Data qualification can also be switched off, so the block passes the raw address hit through unchanged. A comparator that is typed for instruction fetch or execute must never be data-qualified, so that combination forces the output low.

Reference value and mask are held in two internal registers loaded through a simple write strobe. The qualified output is registered, one clock after its inputs.

Top module: `data_value_qualifier`

## Requirements
- R1: After reset the output `qual_hit` is 0, and both the reference value and the mask register are 0.
- R2: When `dcmp_en` is 0, `qual_hit` equals `addr_hit` of the previous cycle, whatever the transfer, data or type inputs are.
- R3: When `dcmp_en` is 1 and `xfer_valid` is 0, `qual_hit` is 0 in the next cycle.
- R4: A mask bit of 1 removes that bit position from the comparison. With the mask all ones, any data value counts as equal.
- R5: With data qualification enabled, `qual_hit` is 1 only if `addr_hit` was 1 and the data result agreed. An `addr_hit` of 0 always gives 0.
- R6: When `cfg_invert` is 1, the data result is true when at least one unmasked bit differs from the reference value, and false when all unmasked bits agree.
- R7: `cmp_kind` encodes the linked comparator type. Values 0 to 3 (bit 2 = 0) are instruction types. Any of them with `dcmp_en` = 1 holds `qual_hit` at 0.
- R8: A write with `wr_en` = 1 loads `wr_data` into the value register when `wr_sel` = 0, or into the mask register when `wr_sel` = 1. The new contents govern transfers presented in the cycle after the write.
- R9: `cmp_kind` 5 is load-only: a store (`xfer_store` = 1) gives 0. `cmp_kind` 6 is store-only: a load gives 0. Kinds 4 and 7 accept both directions.
- R10: `qual_hit` is registered, so the result for inputs presented in one cycle appears after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 value, 1 mask |
| wr_data | input | DATA_W | Write data |
| dcmp_en | input | 1 | Enable data qualification (0 = pass address hit) |
| cfg_invert | input | 1 | Match on data mismatch |
| cmp_kind | input | 3 | Linked comparator access type |
| addr_hit | input | 1 | Raw address or range match |
| xfer_valid | input | 1 | A load or store is presented this cycle |
| xfer_store | input | 1 | Transfer direction: 1 store, 0 load |
| data_bus | input | DATA_W | Transferred data value |
| qual_hit | output | 1 | Qualified match, registered |

## Verification
Value and mask live only inside the block, so a corrupt register cannot be read back. It shows up as a wrong `qual_hit` on the first qualified transfer whose data touches the affected bit. The bench therefore pairs each write with data words that differ from the reference in a single masked or unmasked bit. A wrong gating decision (type, direction, validity, sense) shows at the port exactly one clock after the offending input, because the output stage holds no other state.

// File: rtl/dvq_pkg.sv
package dvq_pkg;

   // Linked comparator access type; bit 2 separates data from instruction side
   typedef enum logic [2:0] {
      AK_FETCH      = 3'b000,
      AK_EXEC       = 3'b001,
      AK_EXEC_PASS  = 3'b010,
      AK_EXEC_FAIL  = 3'b011,
      AK_DATA_ANY   = 3'b100,
      AK_DATA_LOAD  = 3'b101,
      AK_DATA_STORE = 3'b110,
      AK_DATA_ANY2  = 3'b111
   } access_kind_e;

   typedef enum logic {
      SEL_VALUE = 1'b0,
      SEL_MASK  = 1'b1
   } reg_sel_e;

   function automatic logic kind_is_data(input access_kind_e k);
      return k[2];
   endfunction

   function automatic logic dir_allowed(input access_kind_e k, input logic is_store);
      logic ok;
      case (k)
         AK_DATA_LOAD:  ok = ~is_store;
         AK_DATA_STORE: ok = is_store;
         default:       ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/dvq_regs.sv
module dvq_regs
   import dvq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ref_value,
   output logic [DATA_W-1:0] ref_mask
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_value <= '0;
         ref_mask  <= '0;
      end else if (wr_en) begin
         if (sel == SEL_VALUE) ref_value <= wr_data;
         else                  ref_mask  <= wr_data;
      end
   end

   p_value_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (ref_value == $past(wr_data)));
   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (ref_mask == $past(wr_data)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ref_value) && $stable(ref_mask)));

endmodule

// File: rtl/dvq_masked_cmp.sv
module dvq_masked_cmp #(
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit LANE_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] ref_value,
   input  logic [DATA_W-1:0] ref_mask,
   output logic              data_eq
);

   localparam int N_LANES = DATA_W / LANE_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("dvq_masked_cmp: DATA_W must be positive");
   end
   if (LANE_W < 1 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("dvq_masked_cmp: LANE_W must divide DATA_W");
   end

   // A mask bit of 1 excludes that bit from the comparison
   logic [DATA_W-1:0] diff_bits;
   assign diff_bits = (data_in ^ ref_value) & ~ref_mask;

   if (LANE_TREE) begin : g_lanes
      logic [N_LANES-1:0] lane_ok;
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         assign lane_ok[i] = ~|diff_bits[i*LANE_W +: LANE_W];
      end
      assign data_eq = &lane_ok;
   end else begin : g_flat
      assign data_eq = ~|diff_bits;
   end

endmodule

// File: rtl/dvq_gate.sv
module dvq_gate
   import dvq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dcmp_en,
   input  logic       cfg_invert,
   input  logic [2:0] cmp_kind,
   input  logic       addr_hit,
   input  logic       xfer_valid,
   input  logic       xfer_store,
   input  logic       data_eq,
   output logic       qual_hit
);

   access_kind_e kind;
   logic         data_ok;
   logic         qual_next;

   assign kind = access_kind_e'(cmp_kind);

   always_comb begin
      data_ok = data_eq ^ cfg_invert;
      if (!dcmp_en)                         qual_next = addr_hit;
      else if (!kind_is_data(kind))         qual_next = 1'b0;
      else if (!xfer_valid)                 qual_next = 1'b0;
      else if (!dir_allowed(kind, xfer_store)) qual_next = 1'b0;
      else                                  qual_next = addr_hit & data_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_hit <= 1'b0;
      else        qual_hit <= qual_next;
   end

   p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dcmp_en |=> (qual_hit == $past(addr_hit)));
   p_no_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dcmp_en && !xfer_valid) |=> !qual_hit);
   p_addr_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hit |=> !qual_hit);
   p_instr_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dcmp_en && !cmp_kind[2]) |=> !qual_hit);
   p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dcmp_en && ((cmp_kind == 3'd5 && xfer_store) || (cmp_kind == 3'd6 && !xfer_store)))
      |=> !qual_hit);

endmodule

// File: rtl/data_value_qualifier.sv
module data_value_qualifier
   import dvq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit LANE_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              dcmp_en,
   input  logic              cfg_invert,
   input  logic [2:0]        cmp_kind,
   input  logic              addr_hit,
   input  logic              xfer_valid,
   input  logic              xfer_store,
   input  logic [DATA_W-1:0] data_bus,
   output logic              qual_hit
);

   logic [DATA_W-1:0] ref_value;
   logic [DATA_W-1:0] ref_mask;
   logic              data_eq;

   dvq_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .ref_value (ref_value),
      .ref_mask  (ref_mask)
   );

   dvq_masked_cmp #(
      .DATA_W    (DATA_W),
      .LANE_W    (LANE_W),
      .LANE_TREE (LANE_TREE)
   ) u_cmp (
      .data_in   (data_bus),
      .ref_value (ref_value),
      .ref_mask  (ref_mask),
      .data_eq   (data_eq)
   );

   dvq_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .dcmp_en    (dcmp_en),
      .cfg_invert (cfg_invert),
      .cmp_kind   (cmp_kind),
      .addr_hit   (addr_hit),
      .xfer_valid (xfer_valid),
      .xfer_store (xfer_store),
      .data_eq    (data_eq),
      .qual_hit   (qual_hit)
   );

   // With every bit masked, a valid, allowed data transfer follows only addr_hit and sense
   p_mask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dcmp_en && cmp_kind[2] && xfer_valid && addr_hit && (&ref_mask)
       && cmp_kind != 3'd5 && cmp_kind != 3'd6)
      |=> (qual_hit == !$past(cfg_invert)));
   p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dcmp_en && cmp_kind == 3'd4 && xfer_valid && addr_hit
       && (((data_bus ^ ref_value) & ~ref_mask) != '0))
      |=> (qual_hit == $past(cfg_invert)));

endmodule

// File: tb/test_data_value_qualifier.sv
module test_data_value_qualifier;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          dcmp_en = 1'b0;
   logic          cfg_invert = 1'b0;
   logic [2:0]    cmp_kind = 3'd4;
   logic          addr_hit = 1'b0;
   logic          xfer_valid = 1'b0;
   logic          xfer_store = 1'b0;
   logic [DW-1:0] data_bus = '0;
   logic          qual_hit;

   int n_run = 0;
   int n_fail = 0;
   logic [DW-1:0] sh_val = '0;
   logic [DW-1:0] sh_msk = '0;

   always #2.5 clk = ~clk;

   data_value_qualifier i_data_value_qualifier (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .dcmp_en(dcmp_en), .cfg_invert(cfg_invert), .cmp_kind(cmp_kind),
      .addr_hit(addr_hit), .xfer_valid(xfer_valid), .xfer_store(xfer_store),
      .data_bus(data_bus), .qual_hit(qual_hit)
   );

   function automatic bit model(bit en, bit inv, logic [2:0] k, bit ah, bit xv, bit st,
                                logic [DW-1:0] d, logic [DW-1:0] v, logic [DW-1:0] m);
      bit eq;
      if (!en) return ah;
      if (!k[2]) return 1'b0;
      if (!xv) return 1'b0;
      if (k == 3'd5 && st) return 1'b0;
      if (k == 3'd6 && !st) return 1'b0;
      eq = (((d ^ v) & ~m) == '0);
      return ah & (eq ^ inv);
   endfunction

   task automatic check(string req, bit got, bit exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: qual_hit=%0b expected=%0b", req, got, exp);
      end
   endtask

   // Present one cycle of inputs, sample after the registering edge
   task automatic step(string req, bit en, bit inv, logic [2:0] k, bit ah, bit xv,
                       bit st, logic [DW-1:0] d);
      @(negedge clk);
      dcmp_en = en; cfg_invert = inv; cmp_kind = k; addr_hit = ah;
      xfer_valid = xv; xfer_store = st; data_bus = d;
      @(posedge clk); #1;
      check(req, qual_hit, model(en, inv, k, ah, xv, st, d, sh_val, sh_msk));
   endtask

   task automatic write_reg(bit sel, logic [DW-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = v;
      @(posedge clk); #1;
      if (sel) sh_msk = v; else sh_val = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      #1 check("R1 reset output", qual_hit, 1'b0);
      // Value and mask 0 after reset: only data 0 matches
      step("R1 zero value matches", 1, 0, 3'd4, 1, 1, 0, 32'h0);
      step("R1 zero mask all bits", 1, 0, 3'd4, 1, 1, 0, 32'h0000_0100);
   endtask

   task automatic t_bypass;
      step("R2 bypass hit", 0, 0, 3'd0, 1, 0, 0, 32'hDEAD_BEEF);
      step("R2 bypass miss", 0, 1, 3'd4, 0, 1, 1, 32'h0);
      step("R2 bypass ignores data", 0, 0, 3'd5, 1, 1, 1, 32'h1234_5678);
   endtask

   task automatic t_no_xfer;
      write_reg(0, 32'hA5A5_0F0F);
      step("R3 no transfer", 1, 0, 3'd4, 1, 0, 0, 32'hA5A5_0F0F);
      step("R3 no transfer inverted", 1, 1, 3'd4, 1, 0, 0, 32'h0);
   endtask

   task automatic t_match_and;
      step("R5 data equal addr hit", 1, 0, 3'd4, 1, 1, 0, 32'hA5A5_0F0F);
      step("R5 data equal addr miss", 1, 0, 3'd4, 0, 1, 0, 32'hA5A5_0F0F);
      step("R5 data differs", 1, 0, 3'd4, 1, 1, 1, 32'hA5A5_0F0E);
   endtask

   task automatic t_mask;
      write_reg(1, 32'h0000_00FF);
      step("R4 masked low byte differs", 1, 0, 3'd4, 1, 1, 0, 32'hA5A5_0F00);
      step("R4 unmasked bit differs", 1, 0, 3'd4, 1, 1, 0, 32'hA5A5_1F0F);
      write_reg(1, 32'hFFFF_FFFF);
      step("R4 all-ones mask", 1, 0, 3'd4, 1, 1, 0, 32'h1357_9BDF);
      step("R4 all-ones mask inverted", 1, 1, 3'd4, 1, 1, 1, 32'h0);
      write_reg(1, 32'h0);
   endtask

   task automatic t_invert;
      step("R6 invert differs", 1, 1, 3'd4, 1, 1, 0, 32'h25A5_0F0F);
      step("R6 invert equal", 1, 1, 3'd4, 1, 1, 0, 32'hA5A5_0F0F);
      step("R6 invert addr miss", 1, 1, 3'd4, 0, 1, 0, 32'h0);
   endtask

   task automatic t_instr;
      for (int k = 0; k < 4; k++)
         step("R7 instruction kind", 1, 0, 3'(k), 1, 1, 0, 32'hA5A5_0F0F);
      step("R7 instruction kind inverted", 1, 1, 3'd1, 1, 1, 0, 32'h0);
   endtask

   task automatic t_dir;
      step("R9 load-only store", 1, 0, 3'd5, 1, 1, 1, 32'hA5A5_0F0F);
      step("R9 load-only load", 1, 0, 3'd5, 1, 1, 0, 32'hA5A5_0F0F);
      step("R9 store-only load", 1, 0, 3'd6, 1, 1, 0, 32'hA5A5_0F0F);
      step("R9 store-only store", 1, 0, 3'd6, 1, 1, 1, 32'hA5A5_0F0F);
      step("R9 kind 7 store", 1, 0, 3'd7, 1, 1, 1, 32'hA5A5_0F0F);
   endtask

   task automatic t_write_timing;
      // Write and transfer in the same cycle: old value governs
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0BAD_F00D;
      dcmp_en = 1; cfg_invert = 0; cmp_kind = 3'd4; addr_hit = 1;
      xfer_valid = 1; xfer_store = 0; data_bus = 32'h0BAD_F00D;
      @(posedge clk); #1;
      check("R8 same-cycle write uses old value", qual_hit,
            model(1, 0, 3'd4, 1, 1, 0, 32'h0BAD_F00D, sh_val, sh_msk));
      sh_val = 32'h0BAD_F00D;
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk); #1;
      check("R8 new value next cycle", qual_hit, 1'b1);
   endtask

   task automatic t_latency;
      step("R10 setup", 1, 0, 3'd4, 0, 1, 0, 32'h0BAD_F00D);
      @(negedge clk);
      addr_hit = 1;
      #1 check("R10 no combinational path", qual_hit, 1'b0);
      @(posedge clk); #1;
      check("R10 one-cycle latency", qual_hit, 1'b1);
   endtask

   initial begin : watchdog
      #200000;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_bypass();
      t_no_xfer();
      t_match_and();
      t_mask();
      t_invert();
      t_instr();
      t_dir();
      t_write_timing();
      t_latency();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule